// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster input clock. A programmable divisor with an 8-bit integer part and a 4-bit fraction sets the average output period. An internal phase accumulator tracks the position inside the current output period in sixteenths of an input cycle. The rising and falling edges of the output are placed independently, each at a half-cycle position that is rounded to the nearest input edge. Each output period also produces a one-cycle enable pulse. Logic running on the input clock uses this pulse to advance one pixel.

A new divisor applies only from the next period boundary, so a change in mid-period never produces a runt pulse. A synchronous bypass switches the output to the input clock itself and holds the enable permanently high. When bypass is released, a fresh period starts at phase zero.

Top module: `pxdiv_frac_clkgen`

## Requirements
- R1: The divisor input holds the integer part in bits [11:4] and the fraction in bits [3:0]. An integer divisor N (written N<<4, N from 1 to 255) produces one tick every N input cycles.
- R2: A fractional divisor D makes the n-th tick after a restart at phase zero fall exactly ceil(n*D/16) input cycles after the restart tick.
- R3: A divisor whose integer part is zero is used as if its integer part were one, with the fraction kept.
- R4: After reset the divisor is 0x10 (divide by one) and the phase is zero. While reset is held and until the first edge after it, pix_tick_o is 1 and pix_clk_o is 0.
- R5: An edge position p is in half-cycle units. The edge takes effect in the input cycle of the period whose phase ph (in sixteenths) satisfies ph <= 8p+8 < ph+16, which rounds the position to the nearest input edge.
- R6: pix_clk_o changes one input cycle after the cycle that reaches an edge. If the rising and falling positions fall in the same cycle, the rising edge wins.
- R7: A rising position of 0 and a falling position of N with an even integer divisor N gives an output that is high for N/2 cycles of every N.
- R8: A divisor change made in mid-period leaves the current period length unchanged. The new value is loaded at the next period boundary.
- R9: The bypass input is registered. While it is in effect, pix_tick_o is 1 on every cycle and pix_clk_o equals the input clock. After release, the first cycle starts a period at phase zero with a tick, and pix_clk_o is low.
- R10: An edge position that lies beyond the current period is never reached, so the output holds its level through that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low reset |
| div_cfg_i | input | 12 | Divisor, integer [11:4], fraction [3:0] |
| rise_pos_i | input | 9 | Rising edge position, half-cycle units |
| fall_pos_i | input | 9 | Falling edge position, half-cycle units |
| bypass_i | input | 1 | Synchronous bypass request |
| pix_clk_o | output | 1 | Divided pixel clock level |
| pix_tick_o | output | 1 | One-cycle pulse at each period start |

## Verification
A wrong phase value shows at the tick output at the very next period boundary. Tick spacing then drifts from the ceil(n*D/16) schedule, and the error never corrects itself. A divisor loaded too early changes the length of the period that is already running, and this appears within one period. An edge comparator that is off by one moves the output transition by one cycle, and this shows in the first period after the edge positions are set. The scoreboard compares both outputs on every cycle, so each of these faults appears in the cycle it occurs.

// File: rtl/pxdiv_pkg.sv
package pxdiv_pkg;
   typedef enum int {
      EDGE_RISE = 0,
      EDGE_FALL = 1
   } edge_kind_e;
   localparam int EDGE_COUNT = 2;
endpackage

// File: rtl/pxdiv_phase_acc.sv
module pxdiv_phase_acc #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    restart_i,
   input  logic [INT_W+FRAC_W-1:0] div_req_i,
   output logic [INT_W+FRAC_W-1:0] phase_o,
   output logic                    start_o
);
   localparam int PH_W  = INT_W + FRAC_W;
   localparam int SUM_W = PH_W + 1;
   localparam logic [PH_W-1:0] ONE_CYC = PH_W'(1) << FRAC_W;

   if (INT_W < 1 || FRAC_W < 1) begin : g_bad_width
      $error("pxdiv_phase_acc: INT_W and FRAC_W must be at least 1");
   end

   logic [PH_W-1:0]  phase_q, div_act_q, div_clamped;
   logic [SUM_W-1:0] sum_adv;
   logic             wrap, start_q;

   // integer part of zero is treated as one, fraction kept
   always_comb begin
      if (div_req_i[PH_W-1:FRAC_W] == '0) div_clamped = div_req_i | ONE_CYC;
      else                                div_clamped = div_req_i;
   end

   assign sum_adv = {1'b0, phase_q} + SUM_W'(ONE_CYC);
   assign wrap    = sum_adv >= {1'b0, div_act_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q   <= '0;
         div_act_q <= ONE_CYC;
         start_q   <= 1'b1;
      end else if (restart_i) begin
         phase_q   <= '0;
         div_act_q <= div_clamped;
         start_q   <= 1'b1;
      end else begin
         start_q <= wrap;
         if (wrap) begin
            phase_q   <= PH_W'(sum_adv - {1'b0, div_act_q});
            div_act_q <= div_clamped;
         end else begin
            phase_q <= sum_adv[PH_W-1:0];
         end
      end
   end

   assign phase_o = phase_q;
   assign start_o = start_q;

   assert_phase_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_q < div_act_q);
   assert_div_held_midperiod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!restart_i && !wrap) |=> $stable(div_act_q));
   assert_wrap_lands_first_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap && !restart_i) |=> (phase_q < ONE_CYC));
   assert_integer_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_act_q[PH_W-1:FRAC_W] != '0);
endmodule

// File: rtl/pxdiv_edge_gen.sv
module pxdiv_edge_gen #(
   parameter int PH_W   = 12,
   parameter int FRAC_W = 4,
   parameter int POS_W  = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [PH_W-1:0]  phase_i,
   input  logic [POS_W-1:0] rise_pos_i,
   input  logic [POS_W-1:0] fall_pos_i,
   output logic             clk_o
);
   import pxdiv_pkg::*;

   localparam int POS_SPAN = POS_W + FRAC_W - 1;
   localparam int CMP_W    = ((PH_W > POS_SPAN) ? PH_W : POS_SPAN) + 1;
   localparam logic [CMP_W-1:0] HALF_STEP = CMP_W'(1) << (FRAC_W - 1);
   localparam logic [CMP_W-1:0] FULL_STEP = CMP_W'(1) << FRAC_W;

   if (POS_W < 1) begin : g_bad_pos
      $error("pxdiv_edge_gen: POS_W must be at least 1");
   end

   logic [POS_W-1:0]      pos [EDGE_COUNT];
   logic [EDGE_COUNT-1:0] hit;
   logic                  clk_q;

   assign pos[EDGE_RISE] = rise_pos_i;
   assign pos[EDGE_FALL] = fall_pos_i;

   for (genvar e = 0; e < EDGE_COUNT; e++) begin : g_edge
      logic [CMP_W-1:0] target, lo;
      assign target = (CMP_W'(pos[e]) << (FRAC_W - 1)) + HALF_STEP;
      assign lo     = CMP_W'(phase_i);
      assign hit[e] = (lo <= target) && (target < lo + FULL_STEP);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             clk_q <= 1'b0;
      else if (restart_i)      clk_q <= 1'b0;
      else if (hit[EDGE_RISE]) clk_q <= 1'b1;
      else if (hit[EDGE_FALL]) clk_q <= 1'b0;
   end

   assign clk_o = clk_q;

   assert_rise_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[EDGE_RISE] && !restart_i) |=> clk_q);
   assert_no_edge_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit == '0 && !restart_i) |=> $stable(clk_q));
endmodule

// File: rtl/pxdiv_frac_clkgen.sv
module pxdiv_frac_clkgen #(
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 4,
   parameter int POS_W      = 9,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [INT_W+FRAC_W-1:0] div_cfg_i,
   input  logic [POS_W-1:0]        rise_pos_i,
   input  logic [POS_W-1:0]        fall_pos_i,
   input  logic                    bypass_i,
   output logic                    pix_clk_o,
   output logic                    pix_tick_o
);
   localparam int PH_W = INT_W + FRAC_W;

   logic [PH_W-1:0] phase;
   logic            start, div_clk, byp_q;

   if (HAS_BYPASS) begin : g_bypass
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) byp_q <= 1'b0;
         else         byp_q <= bypass_i;
      end
      assign pix_clk_o  = byp_q ? clk_i : div_clk;
      assign pix_tick_o = byp_q | start;

      assert_bypass_ticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         bypass_i |=> pix_tick_o);
   end else begin : g_no_bypass
      assign byp_q      = 1'b0;
      assign pix_clk_o  = div_clk;
      assign pix_tick_o = start;
   end

   pxdiv_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (byp_q),
      .div_req_i (div_cfg_i),
      .phase_o   (phase),
      .start_o   (start)
   );

   pxdiv_edge_gen #(.PH_W(PH_W), .FRAC_W(FRAC_W), .POS_W(POS_W)) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (byp_q),
      .phase_i    (phase),
      .rise_pos_i (rise_pos_i),
      .fall_pos_i (fall_pos_i),
      .clk_o      (div_clk)
   );
endmodule

// File: tb/pxdiv_frac_clkgen_test.sv
module pxdiv_frac_clkgen_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div_cfg = 12'h010;
   logic [8:0]  rise_pos = '0;
   logic [8:0]  fall_pos = 9'd2;
   logic        bypass = 1'b0;
   logic        pix_clk, pix_tick;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      bit    tick;
      bit    clk_lvl;
      bit    byp;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   pxdiv_frac_clkgen uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .div_cfg_i  (div_cfg),
      .rise_pos_i (rise_pos),
      .fall_pos_i (fall_pos),
      .bypass_i   (bypass),
      .pix_clk_o  (pix_clk),
      .pix_tick_o (pix_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state: time of current period start in sixteenths
   int m_t = 0, m_pstart = 0, m_dcur = 16;
   bit m_tick = 1'b1, m_clk = 1'b0, m_byp = 1'b0;

   function automatic int eff_div(int v);
      if ((v >> 4) == 0) return v | 16;   // R3
      return v;
   endfunction

   task automatic model_step(string tag);
      exp_t it;
      if (m_byp) begin
         m_t = 0; m_pstart = 0; m_dcur = eff_div(int'(div_cfg));
         m_tick = 1'b1; m_clk = 1'b0;
      end else begin
         int ph, tr, tf;
         ph = 16 * m_t - m_pstart;
         tr = int'(rise_pos) * 8 + 8;
         tf = int'(fall_pos) * 8 + 8;
         if (ph <= tr && tr < ph + 16)      m_clk = 1'b1;
         else if (ph <= tf && tf < ph + 16) m_clk = 1'b0;
         m_t++;
         if (16 * m_t >= m_pstart + m_dcur) begin
            m_pstart += m_dcur;
            m_dcur   = eff_div(int'(div_cfg));
            m_tick   = 1'b1;
         end else begin
            m_tick = 1'b0;
         end
      end
      m_byp = bypass;
      it.tick = m_tick; it.clk_lvl = m_clk; it.byp = m_byp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) begin
         model_step(tag);
         @(negedge clk);
      end
   endtask

   // monitor: samples a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (sb_q.size() > 0) begin
            exp_t e;
            bit   et, ec;
            e  = sb_q.pop_front();
            et = e.tick;
            ec = e.byp ? 1'b1 : e.clk_lvl;   // in bypass the output follows clk, high here
            if (e.byp) et = 1'b1;
            n_checks++;
            if (pix_tick !== et || pix_clk !== ec) begin
               n_fail++;
               $display("FAIL %s: tick=%0b exp %0b, clk=%0b exp %0b at %0t",
                        e.tag, pix_tick, et, pix_clk, ec, $time);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R4: reset state held
      n_checks++;
      if (pix_tick !== 1'b1 || pix_clk !== 1'b0) begin
         n_fail++;
         $display("FAIL R4 reset: tick=%0b exp 1, clk=%0b exp 0", pix_tick, pix_clk);
      end
      rst_n = 1'b1;
      run(6, "R4 default divide by one");

      div_cfg = 12'h040; rise_pos = 9'd0; fall_pos = 9'd4;
      run(20, "R7 R1 divide by 4 half duty");

      div_cfg = 12'h030; fall_pos = 9'd3;
      run(15, "R5 rounding divide by 3");

      div_cfg = 12'h018; fall_pos = 9'd1;
      run(20, "R2 divide by 1.5");

      div_cfg = 12'h05C; rise_pos = 9'd2; fall_pos = 9'd7;
      run(40, "R2 R5 divide by 5.75");

      div_cfg = 12'h0A0; rise_pos = 9'd0; fall_pos = 9'd10;
      run(25, "R1 divide by 10");
      run(3, "R8 before change");
      div_cfg = 12'h030; fall_pos = 9'd3;
      run(20, "R8 mid-period change");

      div_cfg = 12'h008; fall_pos = 9'd1;
      run(12, "R3 zero integer with fraction");
      div_cfg = 12'h000;
      run(8, "R3 zero divisor");

      div_cfg = 12'h040; rise_pos = 9'd2; fall_pos = 9'd2;
      run(12, "R6 equal positions");

      rise_pos = 9'd0; fall_pos = 9'd20;
      run(12, "R10 fall beyond period");

      bypass = 1'b1; fall_pos = 9'd4;
      run(6, "R9 bypass active");
      bypass = 1'b0;
      run(15, "R9 bypass release");

      div_cfg = 12'hFF0; rise_pos = 9'd0; fall_pos = 9'd255;
      run(600, "R1 divide by 255");

      @(posedge clk);
      #(CLK_PERIOD/2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule